// File: doc/BRIEF.md
# PS/2 Device Frame Receiver

This block takes the clock and data lines of a PS/2 keyboard or mouse, brings both into the system clock domain, and collects one 11-bit frame per transfer. The device drives the line clock, and every bit is taken on a high-to-low transition of that clock. A finished frame is checked for a low start bit, a high stop bit and odd parity. Only a frame that passes all three checks updates the byte output and raises the interrupt.

The interrupt is a stretched pulse and needs no acknowledge. The byte output has no valid/ready pair and applies no back-pressure. The host may read it at any time after the interrupt, and it keeps its value until the next good frame replaces it. A host-side transmitter drives the inhibit input while it owns the bus. During that time the receiver stays idle and drops any frame in progress. A frame that stalls in mid-transfer is dropped after a timeout counted in microsecond ticks. Those ticks are divided down from the system clock.

Top module: `ps2_frame_rx`

## Requirements
- R1: A frame is 11 bits in line order: start, eight data bits least significant first, parity, stop. When the frame is good, the data bits appear on `rx_byte_o` with the first data bit at bit 0.
- R2: The data bits and the parity bit together must hold an odd number of ones. When they do not, no interrupt is raised and `rx_byte_o` keeps its value.
- R3: When the start bit is 1 or the stop bit is 0, the frame is dropped. No interrupt is raised and `rx_byte_o` is unchanged.
- R4: Each good frame drives `rx_irq_o` high for exactly `IRQ_HOLD` system clocks. `IRQ_HOLD` is at least 13. The pulse needs no acknowledge.
- R5: `rx_busy_o` goes high once the first falling edge of a frame has been seen. It stays high until the frame completes, is dropped, or times out.
- R6: `rx_byte_o` holds the most recent good byte for as long as no new good frame arrives.
- R7: While `inhibit_i` is high, the receiver stays idle with `rx_busy_o` low. A partly received frame is dropped, and line clock edges are ignored.
- R8: If no falling edge arrives for `TIMEOUT_TICKS` ticks in mid-frame, the receiver returns to idle. The next frame is then received correctly from its start bit.
- R9: After reset, `rx_byte_o` is 0 and both `rx_irq_o` and `rx_busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Line clock driven by the device, asynchronous |
| ps2_dat_i | input | 1 | Line data driven by the device, asynchronous |
| inhibit_i | input | 1 | High while the host transmitter owns the bus |
| rx_byte_o | output | 8 | Last good received byte |
| rx_irq_o | output | 1 | Stretched pulse, one per good frame |
| rx_busy_o | output | 1 | High while a frame is being collected |

## Verification
The assertions check the following on every cycle:
- inhibit forces the receiver idle;
- a falling edge seen in idle starts a frame;
- the receiver never stays busy past the stall limit;
- the byte output changes only on a good frame;
- the interrupt is never shorter than its hold count and never starts after a rejected frame.

Only the bench scenarios can show the rest:
- that line order maps to the right byte bits;
- that each kind of bad frame (parity, start, stop) is rejected;
- that the receiver realigns to the next frame after a timeout or an inhibit.

// File: rtl/ps2rx_pkg.sv
`timescale 1ns/1ps
package ps2rx_pkg;
  localparam int FRAME_LEN = 11;
  localparam int DATA_W    = 8;

  typedef logic [DATA_W-1:0] byte_t;

  // Field layout of a collected frame, bit 0 = first bit on the line.
  typedef struct packed {
    logic  stop;
    logic  par;
    byte_t data;
    logic  start;
  } frame_t;
endpackage

// File: rtl/ps2rx_sync.sv
`timescale 1ns/1ps
module ps2rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_clk_i,
  input  logic line_dat_i,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev_q;

  // Both lines idle high, so the chains reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q      <= '1;
      dt_q      <= '1;
      ck_prev_q <= 1'b1;
    end else begin
      ck_q      <= {ck_q[STAGES-2:0], line_clk_i};
      dt_q      <= {dt_q[STAGES-2:0], line_dat_i};
      ck_prev_q <= ck_q[STAGES-1];
    end
  end

  assign fall_o = ck_prev_q & ~ck_q[STAGES-1];
  assign dat_o  = dt_q[STAGES-1];
endmodule

// File: rtl/ps2rx_shift.sv
`timescale 1ns/1ps
module ps2rx_shift
  import ps2rx_pkg::*;
#(
  parameter int TICK_DIV      = 50,
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  fall_i,
  input  logic  bit_i,
  input  logic  inhibit_i,
  output logic  busy_o,
  output logic  done_o,
  output logic  good_o,
  output byte_t data_o
);
  localparam int CW   = $clog2(FRAME_LEN + 1);
  localparam int DIVW = $clog2(TICK_DIV + 1);
  localparam int TOW  = $clog2(TIMEOUT_TICKS + 1);
  localparam int SW   = FRAME_LEN - 1;

  logic [CW-1:0]   cnt_q;
  logic [SW-1:0]   shreg_q;
  logic [DIVW-1:0] div_q;
  logic [TOW-1:0]  stall_q;
  logic            done_q, good_q;
  byte_t           data_q;

  logic   tick, last, fields_ok;
  frame_t fr;

  assign tick = (div_q == DIVW'(TICK_DIV - 1));
  assign last = (cnt_q == CW'(FRAME_LEN - 1));
  // The bit arriving now is the stop bit; the first ten bits sit in shreg_q.
  assign fr   = {bit_i, shreg_q};
  assign fields_ok = ~fr.start & fr.stop & (^{fr.data, fr.par});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      div_q   <= '0;
      stall_q <= '0;
      done_q  <= 1'b0;
      good_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      good_q <= 1'b0;
      div_q  <= tick ? '0 : div_q + DIVW'(1);
      if (inhibit_i) begin
        cnt_q   <= '0;
        stall_q <= '0;
      end else if (fall_i) begin
        stall_q <= '0;
        shreg_q <= {bit_i, shreg_q[SW-1:1]};
        if (last) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          good_q <= fields_ok;
          data_q <= fr.data;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (cnt_q != '0 && tick) begin
        if (stall_q == TOW'(TIMEOUT_TICKS - 1)) begin
          cnt_q   <= '0;
          stall_q <= '0;
        end else begin
          stall_q <= stall_q + TOW'(1);
        end
      end
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;
  assign good_o = good_q;
  assign data_o = data_q;

  // Checker-side count of cycles spent busy without a line edge.
  int unsigned wait_q;
  always_ff @(posedge clk) begin
    if (rst || !busy_o || fall_i) wait_q <= 0;
    else                          wait_q <= wait_q + 1;
  end

  a_r7_inhibit_idle: assert property (@(posedge clk) disable iff (rst)
    inhibit_i |=> !busy_o);

  a_r5_busy_on_first_fall: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !inhibit_i && !busy_o) |=> busy_o);

  a_r8_stall_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (wait_q <= TICK_DIV * TIMEOUT_TICKS + 2));

  a_r3_bad_start_dropped: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !inhibit_i && last && shreg_q[0]) |=> !good_o);
endmodule

// File: rtl/ps2rx_irq_stretch.sv
`timescale 1ns/1ps
module ps2rx_irq_stretch #(
  parameter int HOLD = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic irq_o
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)                 hold_q <= '0;
    else if (start_i)        hold_q <= HW'(HOLD);
    else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
  end

  assign irq_o = (hold_q != '0);

  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (rst)        run_q <= 0;
    else if (irq_o) run_q <= run_q + 1;
    else            run_q <= 0;
  end

  a_r4_pulse_follows_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> irq_o);

  a_r4_min_length: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> (run_q >= HOLD));
endmodule

// File: rtl/ps2_frame_rx.sv
`timescale 1ns/1ps
module ps2_frame_rx
  import ps2rx_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int TICK_DIV      = 50,
  parameter int TIMEOUT_TICKS = 100,
  parameter int IRQ_HOLD      = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       inhibit_i,
  output logic [7:0] rx_byte_o,
  output logic       rx_irq_o,
  output logic       rx_busy_o
);
  logic  fall, dbit, done, good;
  byte_t data;

  ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .line_clk_i(ps2_clk_i), .line_dat_i(ps2_dat_i),
    .fall_o(fall), .dat_o(dbit)
  );

  ps2rx_shift #(.TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_shift (
    .clk(clk), .rst(rst),
    .fall_i(fall), .bit_i(dbit), .inhibit_i(inhibit_i),
    .busy_o(rx_busy_o), .done_o(done), .good_o(good), .data_o(data)
  );

  ps2rx_irq_stretch #(.HOLD(IRQ_HOLD)) u_irq (
    .clk(clk), .rst(rst), .start_i(good), .irq_o(rx_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)       rx_byte_o <= '0;
    else if (good) rx_byte_o <= data;
  end

  a_r6_byte_held: assert property (@(posedge clk) disable iff (rst)
    !good |=> $stable(rx_byte_o));

  a_r2_no_irq_on_reject: assert property (@(posedge clk) disable iff (rst)
    (done && !good && !rx_irq_o) |=> !rx_irq_o);
endmodule

// File: tb/ps2_frame_rx_test.sv
`timescale 1ns/1ps
module ps2_frame_rx_test;
  localparam int HALF = 20;
  localparam int HOLD = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ps2_clk = 1'b1, ps2_dat = 1'b1, inhibit = 1'b0;
  logic [7:0] rx_byte;
  logic rx_irq, rx_busy;

  int tests = 0, fails = 0;
  int pulses = 0, run = 0, last_run = 0;
  logic [7:0] exp_byte = 8'h00;

  always #2.5 clk = ~clk;

  ps2_frame_rx #(.TICK_DIV(4), .TIMEOUT_TICKS(25), .IRQ_HOLD(HOLD)) uut (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
    .inhibit_i(inhibit), .rx_byte_o(rx_byte), .rx_irq_o(rx_irq), .rx_busy_o(rx_busy)
  );

  // Interrupt pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rx_irq) run <= run + 1;
    else if (run != 0) begin
      last_run <= run;
      pulses   <= pulses + 1;
      run      <= 0;
    end
  end

  // Kinds: 0 good, 1 parity flipped, 2 start bit high, 3 stop bit low.
  localparam logic [9:0] VEC [8] = '{
    {8'hA5, 2'd0}, {8'h3C, 2'd1}, {8'h00, 2'd0}, {8'hFF, 2'd0},
    {8'h5A, 2'd2}, {8'h81, 2'd3}, {8'h12, 2'd0}, {8'hF0, 2'd1}
  };

  function automatic logic [10:0] mk(input logic [7:0] d, input logic [1:0] kind);
    logic par;
    par = ~^d;
    if (kind == 2'd1) par = ~par;
    return {(kind != 2'd3), par, d, (kind == 2'd2)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ps2_dat = f[i];
      repeat (HALF) @(negedge clk);
      ps2_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ps2_clk = 1'b1;
    end
    @(negedge clk) ps2_dat = 1'b1;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 byte after reset", rx_byte, 0);
    chk("R9 irq after reset", rx_irq, 0);
    chk("R9 busy after reset", rx_busy, 0);

    // Table walk: R1, R2, R3, R4, R6
    for (int v = 0; v < 8; v++) begin
      p0 = pulses;
      send(mk(VEC[v][9:2], VEC[v][1:0]), 11);
      settle();
      if (VEC[v][1:0] == 2'd0) begin
        exp_byte = VEC[v][9:2];
        chk("R4 one pulse per good frame", pulses - p0, 1);
        chk("R4 pulse length", last_run, HOLD);
        chk("R1 byte from good frame", rx_byte, exp_byte);
      end else begin
        chk("R2/R3 no pulse on bad frame", pulses - p0, 0);
        chk("R6 byte held after bad frame", rx_byte, exp_byte);
      end
    end

    // R5 busy in mid-frame, R8 timeout then realignment
    send(mk(8'h6B, 2'd0), 3);
    repeat (4) @(negedge clk);
    chk("R5 busy mid-frame", rx_busy, 1);
    repeat (200) @(negedge clk);
    chk("R8 idle after stall", rx_busy, 0);
    p0 = pulses;
    send(mk(8'h6B, 2'd0), 11);
    settle();
    chk("R8 realigned byte", rx_byte, 8'h6B);
    chk("R8 realigned pulse", pulses - p0, 1);
    chk("R5 busy clear after frame", rx_busy, 0);

    // R7 inhibit drops a partial frame and ignores edges
    send(mk(8'h77, 2'd0), 5);
    @(negedge clk) inhibit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 busy low under inhibit", rx_busy, 0);
    p0 = pulses;
    send(mk(8'h77, 2'd0), 11);
    settle();
    chk("R7 no pulse under inhibit", pulses - p0, 0);
    chk("R7 byte unchanged under inhibit", rx_byte, 8'h6B);
    chk("R7 busy stays low", rx_busy, 0);
    @(negedge clk) inhibit = 1'b0;
    send(mk(8'h2C, 2'd0), 11);
    settle();
    chk("R7 reception after inhibit", rx_byte, 8'h2C);

    // Back-to-back good frames
    p0 = pulses;
    send(mk(8'h11, 2'd0), 11);
    repeat (2) @(negedge clk);
    chk("R6 first byte of pair", rx_byte, 8'h11);
    send(mk(8'h22, 2'd0), 11);
    settle();
    chk("R4 two pulses for pair", pulses - p0, 2);
    chk("R1 second byte of pair", rx_byte, 8'h22);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule